// File: doc/BRIEF.md
# Two-Level Pad Function Multiplexer with Keyed Write Protection

This block holds the pad configuration for a set of configurable I/O pads, and software programs it through a small memory-mapped register bus. Two banks share one layout. The primary bank stores, for each pad, a function code, a pull bias and a drive strength. The secondary bank stores, for each pad, an extended function code. It also holds two selectors that choose which source drives each of the two management-data (MDIO) channels. The pad function is resolved in two steps. A primary code in the direct range selects a function on its own. One reserved primary code passes the choice to the secondary word of the same pad.

Each bank has a protection word. Configuration writes into a bank take effect only while that bank is unlocked. Software unlocks or locks a bank by writing a key equal to the bank's own protection-word address, with bit 0 giving the new state. A write refused because its bank is locked sets a sticky error pin. The block drives per-pad decoded function indices, bias and drive codes, and the two MDIO source selects.

The request side is a valid/ready channel. A request moves when `bus_valid` and `bus_ready` are both high at a rising edge. A write takes effect at that edge. A read returns its word on a valid/ready response channel in the following cycle. The response word stays stable until `rsp_ready` is seen high. `bus_ready` stays low while a response is pending, so only one read can be outstanding.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset both banks are locked, every pad word is zero (decoded function 0, pull code 0, drive code 0), both MDIO selects are 0 and `cfg_err` is low.
- R2: Primary word bits 3:0 hold the function code. Codes 0 to 9 give that decoded index directly. Codes 10 to 14 give index 0.
- R3: Primary code 15 defers to secondary word bits 5:0 of the same pad. A value v in 0 to 61 gives index 10+v. The values 62 and 63 give index 0.
- R4: Primary bits 9:8 hold the pull code: 0 no pull, 1 pull-up, 3 pull-down. Code 2 is stored and read back as 2, but drives `pad_pull` as 0.
- R5: Primary bits 11:10 hold the drive code (0 = 4 mA, 1 = 6 mA, 2 = 8 mA, 3 = 12 mA) and drive `pad_drive` unchanged.
- R6: The protection word sits at byte offset 0x400 of each bank. Its key is BASE_ADDR + 0x400 for the primary bank and BASE_ADDR + 0x1000 + 0x400 for the secondary bank. Writing key|1 unlocks the bank and writing key|0 locks it. A read of the protection word returns the key with bit 0 = 1 when unlocked.
- R7: A protection write whose bits 31:1 differ from the key leaves the lock state unchanged.
- R8: The two banks lock and unlock independently.
- R9: A write to a pad word or MDIO select of a locked bank leaves the stored value unchanged and sets `cfg_err`, which then stays high until reset.
- R10: Secondary byte offsets 0x404 and 0x408 hold the 3-bit source selects of MDIO channels 0 and 1 (bits 2:0, 0 = high impedance). They drive `mdio_sel` bits 2:0 and 5:3.
- R11: A read accepted at an edge presents `rsp_valid` with its word after that edge. The word holds stable and `bus_ready` stays low until `rsp_ready` is sampled high.
- R12: Reads are always permitted and return stored fields at their bit positions with other bits zero. Unmapped addresses read 0, and writes to them change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted when high with bus_valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset: bit 12 selects the bank, bits 11:2 the word |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read response word |
| pad_func | output | NUM_PADS*7 | Decoded function index per pad (0..71) |
| pad_pull | output | NUM_PADS*2 | Pull code per pad |
| pad_drive | output | NUM_PADS*2 | Drive code per pad |
| mdio_sel | output | 6 | MDIO source select, channel 0 in bits 2:0 |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
The assertions assume the request side honours the handshake: a request is taken only in a cycle where `bus_ready` is high, and its fields are meaningful only then. The response-hold property assumes the consumer may hold `rsp_ready` low for any number of cycles. The stimulus raises `bus_valid` only while no response is pending, and sometimes holds `rsp_ready` low for several cycles. Random addresses are drawn from the pad, protection and MDIO words, and from unmapped words. Random keys are either exact or deliberately corrupted.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int FUNC_W    = 7;
  localparam int L1_W      = 8;
  localparam int L2_W      = 6;
  localparam int MDIO_W    = 3;
  localparam int NUM_MDIO  = 2;
  localparam int PROT_WORD = 256;
  localparam logic [31:0] PROT_BYTE = 32'h400;
  localparam logic [31:0] BANK_SPAN = 32'h1000;

  localparam logic [3:0] L1_LAST  = 4'd9;
  localparam logic [3:0] L1_DEFER = 4'hF;
  localparam int         L2_BASE  = 10;
  localparam logic [5:0] L2_LAST  = 6'd61;
  localparam int         FUNC_MAX = L2_BASE + 61;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_RSVD = 2'd2,
    PULL_DOWN = 2'd3
  } pull_e;

  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;
    logic [3:0] func;
  } l1_cfg_t;
endpackage

// File: rtl/pinmux_bank.sv
module pinmux_bank #(
  parameter int          NUM_PADS  = 170,
  parameter int          PAD_W     = 8,
  parameter int          NUM_EXTRA = 0,
  parameter int          EXTRA_W   = 1,
  parameter int          IDX_W     = 10,
  parameter int          PROT_IDX  = 256,
  parameter logic [31:0] KEY       = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [31:0]          wr_key,
  input  logic [PAD_W-1:0]     pad_wval,
  input  logic [EXTRA_W-1:0]   ext_wval,
  output logic [NUM_PADS*PAD_W-1:0] pads_flat,
  output logic [((NUM_EXTRA > 0) ? NUM_EXTRA*EXTRA_W : 1)-1:0] ext_flat,
  output logic                 unlocked,
  output logic                 refused
);
  localparam int EXT_BITS = (NUM_EXTRA > 0) ? NUM_EXTRA*EXTRA_W : 1;

  logic wr_to_pad, wr_to_prot, wr_to_ext, key_ok;
  logic unused_ext;

  assign wr_to_pad  = wr_en && (wr_idx < IDX_W'(NUM_PADS));
  assign wr_to_prot = wr_en && (wr_idx == IDX_W'(PROT_IDX));
  assign wr_to_ext  = wr_en && (wr_idx > IDX_W'(PROT_IDX)) &&
                      (wr_idx <= IDX_W'(PROT_IDX + NUM_EXTRA));
  assign key_ok     = (wr_key[31:1] == KEY[31:1]);
  assign refused    = (wr_to_pad || wr_to_ext) && !unlocked;
  assign unused_ext = ^ext_wval;

  always_ff @(posedge clk) begin
    if (!rst_n)                    unlocked <= 1'b0;
    else if (wr_to_prot && key_ok) unlocked <= wr_key[0];
  end

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    logic [PAD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_to_pad && unlocked && (wr_idx == IDX_W'(i))) q <= pad_wval;
    end
    assign pads_flat[i*PAD_W +: PAD_W] = q;
  end

  if (NUM_EXTRA > 0) begin : g_ext
    for (genvar j = 0; j < NUM_EXTRA; j++) begin : g_reg
      logic [EXTRA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (wr_to_ext && unlocked && (wr_idx == IDX_W'(PROT_IDX + 1 + j)))
          q <= ext_wval;
      end
      assign ext_flat[j*EXTRA_W +: EXTRA_W] = q;
    end
  end else begin : g_noext
    assign ext_flat = EXT_BITS'(0);
  end

  // R9: a locked bank keeps its pad words
  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked) |=> $stable(pads_flat) && $stable(ext_flat));

  // R7: a wrong key never moves the lock
  p_badkey_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_to_prot && !key_ok) |=> $stable(unlocked));

  // R6: the lock moves only on a protection-word write
  p_lock_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_to_prot |=> $stable(unlocked));
endmodule

// File: rtl/pinmux_pad_decode.sv
module pinmux_pad_decode
  import pinmux_pkg::*;
(
  input  l1_cfg_t           l1,
  input  logic [L2_W-1:0]   l2,
  output logic [FUNC_W-1:0] func_o,
  output logic [1:0]        pull_o,
  output logic [1:0]        drive_o
);
  always_comb begin
    func_o = '0;
    if (l1.func <= L1_LAST)
      func_o = FUNC_W'(l1.func);
    else if (l1.func == L1_DEFER && l2 <= L2_LAST)
      func_o = FUNC_W'(L2_BASE) + FUNC_W'(l2);
    pull_o  = (l1.pull == PULL_RSVD) ? PULL_NONE : l1.pull;
    drive_o = l1.drive;
  end
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int          NUM_PADS  = 170,
  parameter logic [31:0] BASE_ADDR = 32'h4006_7000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  output logic                       bus_ready,
  input  logic                       bus_write,
  input  logic [12:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_rdata,
  output logic [NUM_PADS*FUNC_W-1:0] pad_func,
  output logic [NUM_PADS*2-1:0]      pad_pull,
  output logic [NUM_PADS*2-1:0]      pad_drive,
  output logic [NUM_MDIO*MDIO_W-1:0] mdio_sel,
  output logic                       cfg_err
);
  localparam int          IDX_W  = 10;
  localparam logic [31:0] KEY_L1 = BASE_ADDR + PROT_BYTE;
  localparam logic [31:0] KEY_L2 = BASE_ADDR + BANK_SPAN + PROT_BYTE;

  logic             fire, do_wr, do_rd, sel_hi;
  logic [IDX_W-1:0] idx, pidx;
  logic [L1_W-1:0]  l1_wval;
  logic [L2_W-1:0]  l2_wval;
  logic [MDIO_W-1:0] ext_wval;
  logic [NUM_PADS*L1_W-1:0] l1_flat;
  logic [NUM_PADS*L2_W-1:0] l2_flat;
  logic [NUM_MDIO*MDIO_W-1:0] md_flat;
  logic             l1_ext_unused;
  logic             unl_l1, unl_l2, ref_l1, ref_l2;
  logic [31:0]      rd_word;
  l1_cfg_t          l1_rd;
  logic [L2_W-1:0]  l2_rd;
  logic             eidx;
  logic             unused_bits;

  assign bus_ready = !rsp_valid;
  assign fire      = bus_valid && bus_ready;
  assign do_wr     = fire && bus_write;
  assign do_rd     = fire && !bus_write;
  assign sel_hi    = bus_addr[12];
  assign idx       = bus_addr[11:2];
  assign l1_wval   = {bus_wdata[11:10], bus_wdata[9:8], bus_wdata[3:0]};
  assign l2_wval   = bus_wdata[5:0];
  assign ext_wval  = bus_wdata[2:0];
  assign unused_bits = ^{bus_wdata[31:12], bus_wdata[7:6], bus_addr[1:0], l1_ext_unused};

  pinmux_bank #(
    .NUM_PADS(NUM_PADS), .PAD_W(L1_W), .NUM_EXTRA(0), .EXTRA_W(1),
    .IDX_W(IDX_W), .PROT_IDX(PROT_WORD), .KEY(KEY_L1)
  ) u_bank_l1 (
    .clk(clk), .rst_n(rst_n), .wr_en(do_wr && !sel_hi), .wr_idx(idx),
    .wr_key(bus_wdata), .pad_wval(l1_wval), .ext_wval(bus_wdata[0]),
    .pads_flat(l1_flat), .ext_flat(l1_ext_unused), .unlocked(unl_l1),
    .refused(ref_l1)
  );

  pinmux_bank #(
    .NUM_PADS(NUM_PADS), .PAD_W(L2_W), .NUM_EXTRA(NUM_MDIO), .EXTRA_W(MDIO_W),
    .IDX_W(IDX_W), .PROT_IDX(PROT_WORD), .KEY(KEY_L2)
  ) u_bank_l2 (
    .clk(clk), .rst_n(rst_n), .wr_en(do_wr && sel_hi), .wr_idx(idx),
    .wr_key(bus_wdata), .pad_wval(l2_wval), .ext_wval(ext_wval),
    .pads_flat(l2_flat), .ext_flat(md_flat), .unlocked(unl_l2),
    .refused(ref_l2)
  );

  assign mdio_sel = md_flat;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_dec
    pinmux_pad_decode u_dec (
      .l1     (l1_cfg_t'(l1_flat[p*L1_W +: L1_W])),
      .l2     (l2_flat[p*L2_W +: L2_W]),
      .func_o (pad_func[p*FUNC_W +: FUNC_W]),
      .pull_o (pad_pull[p*2 +: 2]),
      .drive_o(pad_drive[p*2 +: 2])
    );

    // R3: decoded index stays within the resolved function space
    p_func_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pad_func[p*FUNC_W +: FUNC_W] <= FUNC_W'(FUNC_MAX));

    // R4: the reserved pull code never reaches a pad
    p_pull_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pull[p*2 +: 2] != PULL_RSVD);
  end

  // read mux
  always_comb begin
    pidx  = (idx < IDX_W'(NUM_PADS)) ? idx : '0;
    l1_rd = l1_cfg_t'(l1_flat[int'(pidx)*L1_W +: L1_W]);
    l2_rd = l2_flat[int'(pidx)*L2_W +: L2_W];
    eidx  = (idx == IDX_W'(PROT_WORD + 2));
    rd_word = '0;
    if (idx < IDX_W'(NUM_PADS))
      rd_word = sel_hi ? {26'b0, l2_rd}
                       : {20'b0, l1_rd.drive, l1_rd.pull, 4'b0, l1_rd.func};
    else if (idx == IDX_W'(PROT_WORD))
      rd_word = sel_hi ? {KEY_L2[31:1], unl_l2} : {KEY_L1[31:1], unl_l1};
    else if (sel_hi && (idx == IDX_W'(PROT_WORD + 1) || idx == IDX_W'(PROT_WORD + 2)))
      rd_word = {29'b0, md_flat[int'(eidx)*MDIO_W +: MDIO_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (do_rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               cfg_err <= 1'b0;
    else if (ref_l1 || ref_l2) cfg_err <= 1'b1;
  end

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R11: a pending response holds its word
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  // R11: an accepted read always yields a response
  p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> rsp_valid);

  // R8: a write to one bank never moves the other bank's lock
  p_bank_indep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && sel_hi) |=> $stable(unl_l1));
endmodule

// File: tb/pinmux_ctrl_tb.sv
module pinmux_ctrl_tb;
  localparam int NP = 12;
  localparam logic [31:0] BASE = 32'h4006_7000;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, rsp_ready = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rsp_valid, cfg_err;
  logic [31:0] rsp_rdata;
  logic [NP*7-1:0] pad_func;
  logic [NP*2-1:0] pad_pull, pad_drive;
  logic [5:0] mdio_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] m1 [NP];
  logic [5:0]  m2 [NP];
  logic [2:0]  md [2];
  bit          unl [2];
  bit          err;

  always #10 clk = ~clk;

  pinmux_ctrl #(.NUM_PADS(NP), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_func(pad_func), .pad_pull(pad_pull), .pad_drive(pad_drive),
    .mdio_sel(mdio_sel), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] key_of(input int b);
    return BASE + 32'h400 + (b != 0 ? 32'h1000 : 32'h0);
  endfunction

  function automatic logic [6:0] exp_func(input int p);
    logic [3:0] f = m1[p][3:0];
    if (f <= 4'd9) return 7'(f);
    if (f == 4'hF && m2[p] <= 6'd61) return 7'd10 + 7'(m2[p]);
    return 7'd0;
  endfunction

  function automatic logic [1:0] exp_pull(input int p);
    return (m1[p][9:8] == 2'd2) ? 2'd0 : m1[p][9:8];
  endfunction

  function automatic logic [31:0] exp_read(input int b, input int idx);
    if (idx < NP) return b != 0 ? {26'b0, m2[idx]} : {20'b0, m1[idx]};
    if (idx == 256) return {key_of(b)[31:1], unl[b]};
    if (b != 0 && (idx == 257 || idx == 258)) return {29'b0, md[idx-257]};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    for (int p = 0; p < NP; p++) begin
      chk("R2/R3 func", 32'(pad_func[p*7 +: 7]), 32'(exp_func(p)));
      chk("R4 pull", 32'(pad_pull[p*2 +: 2]), 32'(exp_pull(p)));
      chk("R5 drive", 32'(pad_drive[p*2 +: 2]), 32'(m1[p][11:10]));
    end
    chk("R10 mdio", 32'(mdio_sel), 32'({md[1], md[0]}));
    chk("R9 err", 32'(cfg_err), 32'(err));
  endtask

  task automatic wr(input int b, input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {b[0], 10'(idx), 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    if (idx < NP) begin
      if (unl[b]) begin
        if (b != 0) m2[idx] = d[5:0];
        else m1[idx] = d[11:0] & 12'hF0F;
      end else err = 1;
    end else if (idx == 256) begin
      if (d[31:1] == key_of(b)[31:1]) unl[b] = d[0];
    end else if (b != 0 && (idx == 257 || idx == 258)) begin
      if (unl[b]) md[idx-257] = d[2:0];
      else err = 1;
    end
  endtask

  task automatic rd(input int b, input int idx, input int hold);
    logic [31:0] e;
    e = exp_read(b, idx);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = {b[0], 10'(idx), 2'b00};
    @(negedge clk);
    bus_valid = 0;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R11 bus_ready low", 32'(bus_ready), 32'd0);
    chk("R12 rdata", rsp_rdata, e);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R11 hold valid", 32'(rsp_valid), 32'd1);
      chk("R11 hold data", rsp_rdata, e);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R11 release", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int p = 0; p < NP; p++) begin m1[p] = '0; m2[p] = '0; end
    md[0] = '0; md[1] = '0; unl[0] = 0; unl[1] = 0; err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_outputs();
    chk("R1 ready", 32'(bus_ready), 32'd1);
    rd(0, 256, 0);
    rd(1, 256, 0);
    rd(0, 3, 0);

    // R7 bad key, R6 good key
    wr(0, 256, key_of(0) ^ 32'h10 | 32'h1);
    rd(0, 256, 0);
    wr(0, 256, key_of(0) | 32'h1);
    rd(0, 256, 1);
    // R8 bank 2 still locked: unlock bank 0 only, write to bank 1 refused, sets R9 error
    chk("R9 err before", 32'(cfg_err), 32'd0);
    wr(1, 2, 32'h0000_0005);
    check_outputs();
    rd(1, 2, 0);
    rd(1, 256, 0);
    // R2 direct codes and boundary 9 / 10
    wr(0, 0, 32'h0000_0009);
    wr(0, 1, 32'h0000_000A);
    wr(0, 2, 32'h0000_0C20E);
    check_outputs();
    // R6 unlock secondary, R3 defer with 61 and 62
    wr(1, 256, key_of(1) | 32'h1);
    wr(0, 3, 32'h0000_000F);
    wr(1, 3, 32'd61);
    wr(0, 4, 32'h0000_0B0F);
    wr(1, 4, 32'd62);
    check_outputs();
    // R4 reserved pull read back as stored
    wr(0, 5, 32'h0000_0203);
    rd(0, 5, 2);
    check_outputs();
    // R10 MDIO selects
    wr(1, 257, 32'h0000_0003);
    wr(1, 258, 32'hFFFF_FFFF);
    check_outputs();
    rd(1, 258, 0);
    // R12 unmapped
    wr(1, 300, 32'hFFFF_FFFF);
    rd(1, 300, 0);
    rd(0, 257, 0);
    // R6 relock primary, then locked write ignored
    wr(0, 256, key_of(0));
    wr(0, 0, 32'h0000_0001);
    check_outputs();
    rd(0, 256, 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int b, op, idx;
      logic [31:0] d;
      b  = int'($urandom % 2);
      op = int'($urandom % 10);
      d  = $urandom;
      case (op)
        0, 1: wr(b, 256, key_of(b) | 32'h1);
        2:    wr(b, 256, key_of(b));
        3:    wr(b, 256, (key_of(b) ^ (32'h2 << ($urandom % 30))) | 32'(d[0]));
        4, 5, 6: wr(b, int'($urandom % NP), d);
        7:    wr(1, 257 + int'($urandom % 2), d);
        8: begin
          idx = ($urandom % 4 == 0) ? 256 + int'($urandom % 4) : int'($urandom % (NP + 2));
          rd(b, idx, int'($urandom % 3));
        end
        default: wr(b, 259 + int'($urandom % 40), d);
      endcase
      check_outputs();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule